// File: doc/BRIEF.md
# Two-Channel Square-Wave Generator

The block produces two independent square waves, one per output pin. Each channel has three settings: an enable, a period in clock ticks and a high time in clock ticks. The host converts frequency and duty into tick counts before it writes them. Settings are written one field at a time into a staging bank. They reach the running counters only after a commit strobe.

A commit takes a snapshot of the staged settings of both channels in the same cycle. A running channel keeps its current period to the end and switches to the snapshot at the next period start, so no runt or stretched pulse appears. A channel that is off switches right away. A channel that is off drives a steady low.

The reset defaults depend on the clock frequency. Channel 0 comes up running at `OUT_HZ` with half duty. Channel 1 comes up off, with the same period and high time staged.

Top module: `dual_pwm_gen`

## Requirements
- R1: After reset, channel 0 is enabled with period CLK_HZ/OUT_HZ ticks and high time half of that. Its output is high from the first cycle after reset.
- R2: After reset, channel 1 is disabled and its output is low until a commit enables it.
- R3: While a channel's active enable is 0, its output is constantly low.
- R4: A write with cfg_we_i high stores one field of the channel chosen by cfg_ch_i (0 or 1) into staging only, and the outputs do not change. The field codes on cfg_field_i are: 0 = enable (cfg_data_i bit 0), 1 = period, 2 = high time, 3 = ignored.
- R5: When commit_i is sampled high, the staged settings of both channels are captured together. A disabled channel loads them on the next clock edge. An enabled channel loads them on the edge that ends its current period. The load always starts a new period at count 0.
- R6: An enabled channel with period P and high time H repeats a P-cycle pattern. The output is high in cycles 0 to H-1 of the pattern and low for the rest.
- R7: A high time of 0 gives a constant low output.
- R8: A high time equal to or greater than the period gives a constant high output.
- R9: A period of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Staging write strobe |
| cfg_ch_i | input | 1 | Channel chosen for the write |
| cfg_field_i | input | 2 | Field code: 0 enable, 1 period, 2 high time |
| cfg_data_i | input | CNT_W | Write data |
| commit_i | input | 1 | Capture the staged settings of both channels |
| pwm_o | output | 2 | Square-wave outputs, bit n is channel n |

## Verification
A wrong period counter shows at the pins within one period, as a pattern that drifts from the expected cycle-by-cycle waveform. A commit that loads too early shows as a truncated high or low phase inside the period that was running. A commit that loads too late shows as the old pattern continuing past the boundary. A lost or crossed staging write, or a wrong reset default, shows on the first pattern after the next commit. The bench sweeps small periods and high times with expected levels computed from the cycle index, so each of these faults shows within a few cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned CNT_W  = 32;
  parameter int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    FLD_EN     = 2'd0,
    FLD_PERIOD = 2'd1,
    FLD_HIGH   = 2'd2,
    FLD_NONE   = 2'd3
  } fld_e;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] high;
  } ch_cfg_t;

  // only channel 0 runs out of reset
  function automatic ch_cfg_t reset_cfg(int unsigned ch, longint unsigned clk_hz,
                                        longint unsigned out_hz);
    ch_cfg_t c;
    longint unsigned p;
    p        = clk_hz / out_hz;
    c.en     = (ch == 0);
    c.period = CNT_W'(p);
    c.high   = CNT_W'(p >> 1);
    return c;
  endfunction
endpackage

// File: rtl/pwm_cfg_stage.sv
module pwm_cfg_stage
  import pwm_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter longint unsigned OUT_HZ = 1_000,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CH_W-1:0]            ch_i,
  input  logic [1:0]                 field_i,
  input  logic [CNT_W-1:0]           data_i,
  output ch_cfg_t [NUM_CH-1:0]       stage_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam ch_cfg_t RST = reset_cfg(c, CLK_HZ, OUT_HZ);
    logic sel;
    assign sel = we_i && (ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_o[c] <= RST;
      end else if (sel) begin
        case (fld_e'(field_i))
          FLD_EN:     stage_o[c].en     <= data_i[0];
          FLD_PERIOD: stage_o[c].period <= data_i;
          FLD_HIGH:   stage_o[c].high   <= data_i;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned     CH_IDX = 0,
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter longint unsigned OUT_HZ = 1_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  ch_cfg_t          stage_i,
  output logic             pwm_o,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] high_o
);
  localparam ch_cfg_t RST = reset_cfg(CH_IDX, CLK_HZ, OUT_HZ);

  ch_cfg_t          snap_q, act_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap, load;

  // period 0 counts as 1
  assign last = (act_q.period == '0) ? '0 : act_q.period - 1'b1;
  assign wrap = (cnt_q >= last);
  assign load = pend_q && (!act_q.en || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= RST;
      pend_q <= 1'b0;
    end else if (commit_i) begin
      snap_q <= stage_i;
      pend_q <= 1'b1;
    end else if (load) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST;
      cnt_q <= '0;
    end else begin
      if (load) act_q <= snap_q;
      if (load || !act_q.en || wrap) cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o  = act_q.en && (cnt_q < act_q.high);
  assign en_o   = act_q.en;
  assign cnt_o  = cnt_q;
  assign last_o = last;
  assign high_o = act_q.high;
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import pwm_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter longint unsigned OUT_HZ = 1_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_ch_i,
  input  logic [1:0]       cfg_field_i,
  input  logic [CNT_W-1:0] cfg_data_i,
  input  logic             commit_i,
  output logic [1:0]       pwm_o
);
  ch_cfg_t [NUM_CH-1:0]             stage;
  logic    [NUM_CH-1:0]             ch_en;
  logic    [NUM_CH-1:0][CNT_W-1:0]  ch_cnt, ch_last, ch_high;

  pwm_cfg_stage #(.CLK_HZ(CLK_HZ), .OUT_HZ(OUT_HZ)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .ch_i    (cfg_ch_i),
    .field_i (cfg_field_i),
    .data_i  (cfg_data_i),
    .stage_o (stage)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CH_IDX(c), .CLK_HZ(CLK_HZ), .OUT_HZ(OUT_HZ)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (commit_i),
      .stage_i  (stage[c]),
      .pwm_o    (pwm_o[c]),
      .en_o     (ch_en[c]),
      .cnt_o    (ch_cnt[c]),
      .last_o   (ch_last[c]),
      .high_o   (ch_high[c])
    );
  end
endmodule

// File: rtl/dual_pwm_gen_chk.sv
module dual_pwm_gen_chk
  import pwm_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_CH-1:0]             pwm_o,
  input logic [NUM_CH-1:0]             ch_en,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_last,
  input logic [NUM_CH-1:0][CNT_W-1:0]  ch_high
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r3_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en[c] |-> !pwm_o[c]);

    a_r7_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[c] && ch_high[c] == '0) |-> !pwm_o[c]);

    a_r8_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[c] && ch_high[c] > ch_last[c]) |-> pwm_o[c]);

    a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_en[c] |-> (ch_cnt[c] <= ch_last[c]));

    // settings may only change where a new period starts
    a_r5_no_mid_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[c] && ch_cnt[c] != '0) |-> ($stable(ch_high[c]) && $stable(ch_last[c])));
  end
endmodule

bind dual_pwm_gen dual_pwm_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwm_o   (pwm_o),
  .ch_en   (ch_en),
  .ch_cnt  (ch_cnt),
  .ch_last (ch_last),
  .ch_high (ch_high)
);

// File: tb/sim_dual_pwm_gen.sv
`timescale 1ns/1ps
module sim_dual_pwm_gen;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic         ch = 1'b0;
  logic [1:0]   fld = 2'd0;
  logic [W-1:0] data = '0;
  logic         commit = 1'b0;
  logic [1:0]   pwm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_pwm_gen #(.CLK_HZ(8000), .OUT_HZ(1000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_ch_i(ch),
    .cfg_field_i(fld), .cfg_data_i(data), .commit_i(commit), .pwm_o(pwm)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic c, input logic [1:0] f, input int unsigned d);
    we = 1'b1; ch = c; fld = f; data = W'(d);
    tick();
    we = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    tick();
    commit = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(pwm[0], 1'b1, "R1 reset high");
    chk(pwm[1], 1'b0, "R2 reset low");
    rst_n = 1'b1;

    // R1/R2/R4/R5: default wave, staged writes without commit, then deferred load
    for (int j = 1; j <= 55; j++) begin
      logic e;
      if (j == 17) begin we = 1; ch = 0; fld = 2'd1; data = 5; end
      if (j == 18) begin we = 1; ch = 0; fld = 2'd2; data = 2; end
      if (j == 19) begin we = 1; ch = 0; fld = 2'd3; data = 0; end
      if (j == 34) commit = 1'b1;
      tick();
      we = 1'b0; commit = 1'b0;
      e = (j < 40) ? ((j % 8) < 4) : (((j - 40) % 5) < 2);
      if (j < 17)      chk(pwm[0], e, "R1 default wave");
      else if (j < 40) chk(pwm[0], e, "R4 staged no effect");
      else             chk(pwm[0], e, "R5 load at boundary");
      chk(pwm[1], 1'b0, "R2 ch1 stays low");
    end

    // R5: enabling ch1 with its staged defaults loads on the next edge
    wr(1'b1, 2'd0, 1);
    do_commit();
    for (int i = 0; i < 16; i++) begin
      tick();
      chk(pwm[1], (i % 8) < 4, "R5 ch1 immediate load");
    end

    // R3: disable ch1 again
    wr(1'b1, 2'd0, 0);
    do_commit();
    repeat (10) tick();
    for (int i = 0; i < 12; i++) begin
      chk(pwm[1], 1'b0, "R3 disabled low");
      tick();
    end

    // R6-R9 sweep on ch0, each run from a disabled state
    for (int p = 0; p <= 6; p++) begin
      for (int h = 0; h <= 7; h++) begin
        int pe;
        pe = (p == 0) ? 1 : p;
        wr(1'b0, 2'd0, 0);
        do_commit();
        repeat (10) tick();
        chk(pwm[0], 1'b0, "R3 disabled low");
        wr(1'b0, 2'd1, p);
        wr(1'b0, 2'd2, h);
        wr(1'b0, 2'd0, 1);
        do_commit();
        for (int i = 0; i < 2 * pe + 2; i++) begin
          tick();
          if (h == 0)       chk(pwm[0], 1'b0, "R7 zero high");
          else if (h >= pe) chk(pwm[0], 1'b1, (p == 0) ? "R9 period zero" : "R8 full high");
          else              chk(pwm[0], (i % pe) < h, "R6 pattern");
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule